// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside an SDRAM command bus and follows what the memory is doing. Each clock it reads the four active-low command strobes, the bank select, the address lines, a full-page burst-mode input and a burst-complete pulse. From these it keeps, for every bank, whether a row is open and which row that is.

Every command is checked against the current state of the banks it touches. The checks cover opening a row in a bank that is already open, reading or writing a closed bank, loading the mode register while any bank is open, and issuing commands inside the recovery windows that follow a mode-register load or a precharge. The lengths of those windows are set by two programmable cycle counts. A command that breaks a rule has no effect on the tracked state. The first rule broken is latched as a sticky flag with a 3-bit code. An integration bench or a controller self-check can watch these outputs to catch protocol faults the moment they happen.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, LOAD MODE=0000. cs_n=1 (inhibit) and 0111 (NOP) never change bank state and never raise the error flag.
- R2: An ACTIVE to an idle bank `ba` sets `bank_open[ba]` and stores `addr` in `open_row[ba*13 +: 13]`, both visible in the cycle after the command.
- R3: An ACTIVE to a bank that is already open is illegal, with code 1, and leaves the stored row unchanged.
- R4: A READ or WRITE to an idle bank is illegal, with code 2.
- R5: A PRECHARGE with addr[10]=0 closes only bank `ba`. With addr[10]=1 it closes every bank and `ba` is ignored.
- R6: A READ or WRITE with addr[10]=1 while `full_page` is low closes its bank in the cycle after `burst_done` is pulsed with `burst_ba` naming that bank. Without addr[10], or with `full_page` high, the bank stays open after `burst_done`.
- R7: A LOAD MODE while any bank is open is illegal, with code 3, and it starts no wait window.
- R8: After a LOAD MODE accepted at edge k, any command other than inhibit or NOP at edges k+1 through k+tmrd_cycles-1 is illegal, with code 4. A command at edge k+tmrd_cycles is accepted.
- R9: After a bank is closed at edge k, by PRECHARGE or by auto-precharge, any command that addresses it before edge k+trp_cycles is illegal, with code 5. Commands that address a bank are ACTIVE, READ, WRITE, a single-bank PRECHARGE naming it, an all-bank PRECHARGE and LOAD MODE. Precharging a bank that is already idle starts no window for it.
- R10: When several rules are broken at once, code 4 wins over code 5, and code 5 wins over codes 1 to 3. An illegal command changes no bank state.
- R11: `err_flag` stays set and `err_code` holds the first violation until `err_clr` is pulsed. A violation in the same cycle as `err_clr` is recorded.
- R12: After reset, all banks are idle, all rows read 0, `err_flag` and `err_code` are 0, and no wait window is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address, or column plus auto-precharge / all-bank bit (bit 10) |
| full_page | input | 1 | Burst mode is full page; auto-precharge is ignored |
| burst_done | input | 1 | Pulse: burst on bank `burst_ba` has completed |
| burst_ba | input | 2 | Bank whose burst completed |
| trp_cycles | input | 4 | Precharge recovery length in cycles |
| tmrd_cycles | input | 4 | Mode-load recovery length in cycles |
| err_clr | input | 1 | Pulse to clear the sticky error |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| open_row | output | 52 | Open row per bank, 13 bits each, bank 0 lowest |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation (0 = none) |

## Verification
The bench drives the bank state through patterns that separate the per-bank path from the shared one. It opens single banks and all four together, then closes them with a single-bank precharge and with an all-bank precharge, which shows whether `ba` is honoured or ignored. The auto-precharge bit is tried with and without full-page mode, and with a plain access, to tell command-driven closure from burst-driven closure. The wait windows are probed one cycle before and exactly at their boundary. Commands that break two rules at once show the priority between codes.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_LMR,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ACT_OPEN = 3'd1,
        ERR_RW_IDLE  = 3'd2,
        ERR_LMR_BUSY = 3'd3,
        ERR_MRD_WAIT = 3'd4,
        ERR_RP_WAIT  = 3'd5
    } err_e;

    typedef struct packed {
        cmd_e kind;
        logic bit10;
    } cmd_info_t;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        if (cs_n) return CMD_INHIBIT;
        case ({ras_n, cas_n, we_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b000:  return CMD_LMR;
            default: return CMD_OTHER;
        endcase
    endfunction

    function automatic logic is_exec(input cmd_e k);
        return !(k == CMD_INHIBIT || k == CMD_NOP);
    endfunction

endpackage

// File: rtl/bt_cmd_decode.sv
module bt_cmd_decode
    import bank_trk_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      a10,
    output cmd_info_t info
);
    always_comb begin
        info.kind  = decode_pins(cs_n, ras_n, cas_n, we_n);
        info.bit10 = a10;
    end
endmodule

// File: rtl/bt_bank.sv
module bt_bank #(
    parameter int ROW_W = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             rw_en,
    input  logic             rw_ap,
    input  logic             pre_en,
    input  logic             done_hit,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CNT_W-1:0] trp_cycles,
    output logic             open_q,
    output logic [ROW_W-1:0] row_q,
    output logic             rec
);
    logic             ap_pend;
    logic [CNT_W-1:0] rp_cnt;
    logic [CNT_W-1:0] rp_load;

    assign rp_load = (trp_cycles == '0) ? '0 : trp_cycles - CNT_W'(1);
    assign rec     = (rp_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            row_q   <= '0;
            ap_pend <= 1'b0;
            rp_cnt  <= '0;
        end else begin
            if (rp_cnt != '0) rp_cnt <= rp_cnt - CNT_W'(1);
            if (act_en) begin
                open_q  <= 1'b1;
                row_q   <= row_in;
                ap_pend <= 1'b0;
            end else if (rw_en) begin
                ap_pend <= rw_ap;
            end else if (pre_en) begin
                open_q  <= 1'b0;
                ap_pend <= 1'b0;
                if (open_q) rp_cnt <= rp_load;
            end else if (done_hit && ap_pend) begin
                open_q  <= 1'b0;
                ap_pend <= 1'b0;
                rp_cnt  <= rp_load;
            end
        end
    end

    // R9
    rec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rec |-> !open_q);

    // R3
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && !act_en) |=> $stable(row_q));

    // R6
    ap_close_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && ap_pend && done_hit && !act_en && !rw_en && !pre_en) |=> !open_q);
endmodule

// File: rtl/bt_rules.sv
module bt_rules
    import bank_trk_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             kind,
    input  logic             pre_all,
    input  logic [NBANK-1:0] bank_sel,
    input  logic [NBANK-1:0] bank_open,
    input  logic [NBANK-1:0] bank_rec,
    input  logic [CNT_W-1:0] tmrd_cycles,
    output logic [NBANK-1:0] act_en,
    output logic [NBANK-1:0] rw_en,
    output logic [NBANK-1:0] pre_en,
    output err_e             viol
);
    logic [CNT_W-1:0] mrd_cnt;
    logic             mrd_busy;
    logic [NBANK-1:0] target;
    logic             sel_open;
    logic             ok;

    assign mrd_busy = (mrd_cnt != '0);
    assign sel_open = |(bank_sel & bank_open);

    always_comb begin
        case (kind)
            CMD_ACT, CMD_RD, CMD_WR: target = bank_sel;
            CMD_PRE:                 target = pre_all ? '1 : bank_sel;
            CMD_LMR:                 target = '1;
            default:                 target = '0;
        endcase
    end

    always_comb begin
        viol = ERR_NONE;
        if (is_exec(kind) && mrd_busy) begin
            viol = ERR_MRD_WAIT;
        end else if (|(target & bank_rec)) begin
            viol = ERR_RP_WAIT;
        end else begin
            case (kind)
                CMD_ACT:        if (sel_open)   viol = ERR_ACT_OPEN;
                CMD_RD, CMD_WR: if (!sel_open)  viol = ERR_RW_IDLE;
                CMD_LMR:        if (|bank_open) viol = ERR_LMR_BUSY;
                default:        viol = ERR_NONE;
            endcase
        end
    end

    assign ok     = (viol == ERR_NONE);
    assign act_en = (ok && kind == CMD_ACT) ? bank_sel : '0;
    assign rw_en  = (ok && (kind == CMD_RD || kind == CMD_WR)) ? bank_sel : '0;
    assign pre_en = (ok && kind == CMD_PRE) ? target : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mrd_cnt <= '0;
        end else if (ok && kind == CMD_LMR) begin
            mrd_cnt <= (tmrd_cycles == '0) ? '0 : tmrd_cycles - CNT_W'(1);
        end else if (mrd_busy) begin
            mrd_cnt <= mrd_cnt - CNT_W'(1);
        end
    end

    // R10
    one_act_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_en) && $onehot0(rw_en) && ((act_en & rw_en) == '0));

    // R5
    pre_single_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_PRE && !pre_all && viol == ERR_NONE) |-> ($countones(pre_en) == 1));

    // R1
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_exec(kind) |-> (viol == ERR_NONE && act_en == '0 && rw_en == '0 && pre_en == '0));
endmodule

// File: rtl/bt_err_log.sv
module bt_err_log
    import bank_trk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  err_e viol,
    output logic err_flag_q,
    output err_e err_code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag_q <= 1'b0;
            err_code_q <= ERR_NONE;
        end else begin
            if (clr) begin
                err_flag_q <= 1'b0;
                err_code_q <= ERR_NONE;
            end
            if (viol != ERR_NONE && (clr || !err_flag_q)) begin
                err_flag_q <= 1'b1;
                err_code_q <= viol;
            end
        end
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag_q && !clr) |=> (err_flag_q && $stable(err_code_q)));

    // R11
    code_flag_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag_q == (err_code_q != ERR_NONE));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import bank_trk_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10,
    parameter int CNT_W  = 4,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    input  logic                   full_page,
    input  logic                   burst_done,
    input  logic [BA_W-1:0]        burst_ba,
    input  logic [CNT_W-1:0]       trp_cycles,
    input  logic [CNT_W-1:0]       tmrd_cycles,
    input  logic                   err_clr,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_row,
    output logic                   err_flag,
    output logic [2:0]             err_code
);
    cmd_info_t        info;
    logic [NBANK-1:0] bank_sel;
    logic [NBANK-1:0] bank_open_w;
    logic [NBANK-1:0] bank_rec;
    logic [NBANK-1:0] act_en;
    logic [NBANK-1:0] rw_en;
    logic [NBANK-1:0] pre_en;
    logic [NBANK-1:0] done_hit;
    logic             rw_ap;
    err_e             viol;
    err_e             code_q;

    bt_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (addr[AP_BIT]),
        .info  (info)
    );

    assign bank_sel = {{(NBANK-1){1'b0}}, 1'b1} << ba;
    assign rw_ap    = info.bit10 & ~full_page;

    bt_rules #(.NBANK(NBANK), .CNT_W(CNT_W)) u_rules (
        .clk         (clk),
        .rst         (rst),
        .kind        (info.kind),
        .pre_all     (info.bit10),
        .bank_sel    (bank_sel),
        .bank_open   (bank_open_w),
        .bank_rec    (bank_rec),
        .tmrd_cycles (tmrd_cycles),
        .act_en      (act_en),
        .rw_en       (rw_en),
        .pre_en      (pre_en),
        .viol        (viol)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign done_hit[g] = burst_done && (burst_ba == BA_W'(g));
        bt_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .act_en     (act_en[g]),
            .rw_en      (rw_en[g]),
            .rw_ap      (rw_ap),
            .pre_en     (pre_en[g]),
            .done_hit   (done_hit[g]),
            .row_in     (addr),
            .trp_cycles (trp_cycles),
            .open_q     (bank_open_w[g]),
            .row_q      (open_row[g*ROW_W +: ROW_W]),
            .rec        (bank_rec[g])
        );
    end

    bt_err_log u_log (
        .clk        (clk),
        .rst        (rst),
        .clr        (err_clr),
        .viol       (viol),
        .err_flag_q (err_flag),
        .err_code_q (code_q)
    );

    assign err_code  = code_q;
    assign bank_open = bank_open_w;

    // R7
    lmr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (info.kind == CMD_LMR && viol == ERR_NONE) |-> (bank_open_w == '0));

    // R8
    mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (info.kind == CMD_LMR && viol == ERR_NONE && tmrd_cycles > CNT_W'(1))
        |=> (act_en == '0 && rw_en == '0 && pre_en == '0));

    // R4
    rw_open_chk: assert property (@(posedge clk) disable iff (rst)
        (rw_en != '0) |-> ((rw_en & bank_open_w) == rw_en));
endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_LMR = 4'b0000;
    localparam logic [3:0] P_INH = 4'b1010;
    localparam logic [12:0] A10 = 13'h0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        full_page = 1'b0;
    logic        burst_done = 1'b0;
    logic [1:0]  burst_ba = '0;
    logic [3:0]  trp_cycles = 4'd4;
    logic [3:0]  tmrd_cycles = 4'd3;
    logic        err_clr = 1'b0;
    logic [3:0]  bank_open;
    logic [51:0] open_row;
    logic        err_flag;
    logic [2:0]  err_code;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdram_bank_tracker u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .full_page(full_page), .burst_done(burst_done),
        .burst_ba(burst_ba), .trp_cycles(trp_cycles), .tmrd_cycles(tmrd_cycles),
        .err_clr(err_clr), .bank_open(bank_open), .open_row(open_row),
        .err_flag(err_flag), .err_code(err_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] row_of(input int b);
        return open_row[b*13 +: 13];
    endfunction

    task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic [12:0] a,
                         input logic clr);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b; addr = a; err_clr = clr;
        @(posedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        err_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_done(input logic [1:0] b);
        @(negedge clk);
        burst_done = 1'b1; burst_ba = b;
        @(posedge clk);
        #1;
        burst_done = 1'b0;
    endtask

    task automatic clear_err();
        issue(P_NOP, 2'd0, 13'd0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; full_page = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R12 bank_open", 32'(bank_open), 32'h0);
        check("R12 rows", 32'(open_row[31:0] | open_row[51:32]), 32'h0);
        check("R12 err_flag", 32'(err_flag), 32'h0);
        check("R12 err_code", 32'(err_code), 32'h0);
        issue(P_ACT, 2'd1, 13'h0033, 1'b0);
        check("R12 no window after reset", {28'h0, bank_open}, 32'h2);
    endtask

    task automatic t_nop();
        do_reset();
        issue(P_ACT, 2'd2, 13'h0123, 1'b0);
        issue(P_INH, 2'd2, 13'h0000, 1'b0);
        check("R1 inhibit keeps bank", {28'h0, bank_open}, 32'h4);
        issue(P_NOP, 2'd2, A10, 1'b0);
        check("R1 nop keeps bank", {28'h0, bank_open}, 32'h4);
        check("R1 no error", 32'(err_flag), 32'h0);
    endtask

    task automatic t_activate();
        do_reset();
        issue(P_ACT, 2'd0, 13'h1ABC, 1'b0);
        issue(P_ACT, 2'd3, 13'h0005, 1'b0);
        check("R2 open bits", {28'h0, bank_open}, 32'h9);
        check("R2 row bank0", 32'(row_of(0)), 32'h1ABC);
        check("R2 row bank3", 32'(row_of(3)), 32'h0005);
    endtask

    task automatic t_act_open();
        do_reset();
        issue(P_ACT, 2'd1, 13'd10, 1'b0);
        issue(P_ACT, 2'd1, 13'd20, 1'b0);
        check("R3 code", 32'(err_code), 32'd1);
        check("R3 row unchanged", 32'(row_of(1)), 32'd10);
    endtask

    task automatic t_rw_idle();
        do_reset();
        issue(P_RD, 2'd2, 13'd0, 1'b0);
        check("R4 read idle code", 32'(err_code), 32'd2);
        clear_err();
        issue(P_WR, 2'd2, 13'd0, 1'b0);
        check("R4 write idle code", 32'(err_code), 32'd2);
    endtask

    task automatic t_precharge();
        do_reset();
        for (int b = 0; b < 4; b++) issue(P_ACT, 2'(b), 13'(b + 7), 1'b0);
        check("R5 all open", {28'h0, bank_open}, 32'hF);
        issue(P_PRE, 2'd1, 13'd0, 1'b0);
        check("R5 single close", {28'h0, bank_open}, 32'hD);
        idle(5);
        issue(P_PRE, 2'd2, A10, 1'b0);
        check("R5 all close", {28'h0, bank_open}, 32'h0);
        check("R5 no error", 32'(err_flag), 32'h0);
    endtask

    task automatic t_autopre();
        do_reset();
        issue(P_ACT, 2'd0, 13'd1, 1'b0);
        issue(P_RD, 2'd0, A10, 1'b0);
        check("R6 open until burst end", {28'h0, bank_open}, 32'h1);
        pulse_done(2'd0);
        check("R6 auto close", {28'h0, bank_open}, 32'h0);
        issue(P_ACT, 2'd0, 13'd1, 1'b0);
        check("R9 act after auto close", 32'(err_code), 32'd5);
        clear_err();
        issue(P_ACT, 2'd1, 13'd2, 1'b0);
        issue(P_WR, 2'd1, 13'd0, 1'b0);
        pulse_done(2'd1);
        check("R6 plain write stays open", 32'(bank_open[1]), 32'd1);
        issue(P_ACT, 2'd2, 13'd3, 1'b0);
        full_page = 1'b1;
        issue(P_RD, 2'd2, A10, 1'b0);
        pulse_done(2'd2);
        full_page = 1'b0;
        check("R6 full page stays open", 32'(bank_open[2]), 32'd1);
        check("R6 no error", 32'(err_flag), 32'h0);
    endtask

    task automatic t_lmr_busy();
        do_reset();
        issue(P_ACT, 2'd3, 13'd9, 1'b0);
        issue(P_LMR, 2'd0, 13'd0, 1'b0);
        check("R7 code", 32'(err_code), 32'd3);
        clear_err();
        issue(P_RD, 2'd3, 13'd0, 1'b0);
        check("R7 no window started", 32'(err_flag), 32'h0);
    endtask

    task automatic t_mrd();
        do_reset();
        issue(P_LMR, 2'd0, 13'h0022, 1'b0);
        idle(1);
        issue(P_ACT, 2'd0, 13'd4, 1'b0);
        check("R8 inside window code", 32'(err_code), 32'd4);
        check("R8 inside window ignored", {28'h0, bank_open}, 32'h0);
        clear_err();
        idle(5);
        issue(P_LMR, 2'd0, 13'h0022, 1'b0);
        idle(2);
        issue(P_ACT, 2'd0, 13'd4, 1'b0);
        check("R8 boundary accepted", {28'h0, bank_open}, 32'h1);
        check("R8 boundary no error", 32'(err_flag), 32'h0);
    endtask

    task automatic t_trp();
        do_reset();
        issue(P_ACT, 2'd1, 13'd5, 1'b0);
        issue(P_PRE, 2'd1, 13'd0, 1'b0);
        issue(P_ACT, 2'd2, 13'd6, 1'b0);
        check("R9 other bank free", 32'(err_flag), 32'h0);
        issue(P_ACT, 2'd1, 13'd5, 1'b0);
        check("R9 inside window", 32'(err_code), 32'd5);
        clear_err();
        issue(P_ACT, 2'd1, 13'd5, 1'b0);
        check("R9 boundary accepted", 32'(bank_open[1]), 32'd1);
        check("R9 boundary no error", 32'(err_flag), 32'h0);
        issue(P_PRE, 2'd0, 13'd0, 1'b0);
        issue(P_ACT, 2'd0, 13'd8, 1'b0);
        check("R9 idle precharge no window", 32'(err_flag), 32'h0);
    endtask

    task automatic t_priority();
        do_reset();
        issue(P_ACT, 2'd0, 13'd1, 1'b0);
        issue(P_PRE, 2'd0, 13'd0, 1'b0);
        issue(P_RD, 2'd0, 13'd0, 1'b0);
        check("R10 rp over idle", 32'(err_code), 32'd5);
        do_reset();
        issue(P_LMR, 2'd0, 13'd0, 1'b0);
        issue(P_RD, 2'd1, 13'd0, 1'b0);
        check("R10 mrd over idle", 32'(err_code), 32'd4);
        do_reset();
        issue(P_ACT, 2'd2, 13'd3, 1'b0);
        issue(P_ACT, 2'd0, 13'd1, 1'b0);
        issue(P_PRE, 2'd0, 13'd0, 1'b0);
        issue(P_PRE, 2'd1, A10, 1'b0);
        check("R10 pre-all in window code", 32'(err_code), 32'd5);
        check("R10 illegal ignored", 32'(bank_open[2]), 32'd1);
    endtask

    task automatic t_sticky();
        do_reset();
        issue(P_RD, 2'd0, 13'd0, 1'b0);
        issue(P_ACT, 2'd1, 13'd1, 1'b0);
        issue(P_ACT, 2'd1, 13'd2, 1'b0);
        check("R11 first code held", 32'(err_code), 32'd2);
        check("R11 flag held", 32'(err_flag), 32'd1);
        clear_err();
        check("R11 cleared flag", 32'(err_flag), 32'd0);
        check("R11 cleared code", 32'(err_code), 32'd0);
        issue(P_ACT, 2'd1, 13'd3, 1'b0);
        issue(P_RD, 2'd3, 13'd0, 1'b1);
        check("R11 clear with violation", 32'(err_code), 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_nop();
        t_activate();
        t_act_open();
        t_rw_idle();
        t_precharge();
        t_autopre();
        t_lmr_busy();
        t_mrd();
        t_trp();
        t_priority();
        t_sticky();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule